// File: doc/BRIEF.md
# Time Slot Interchange

This block reorders 8-bit voice samples inside a fixed time-division frame. Samples carry no header. A sample's identity is only its slot position, so the block switches circuits by moving the sample from one slot position to another. One sample enters on the multiplexed input in every clock cycle. Each output slot takes the sample from whichever input slot a programmable connection table names for it.

Incoming samples are written in arrival order into one of two frame banks. The other bank, which holds the previous frame, is read in the order the table gives. The two banks swap roles at every frame boundary, so each sample leaves exactly one frame after it arrived. Call-setup software writes table entries through a small configuration port. Writes go into a staging copy of the table, and the live table is refreshed from it only at a frame boundary. An entry can be marked idle, and an idle output slot carries the fixed pattern 0xFF.

Top module: `tsi_core`

## Requirements
- R1: While reset is held and directly after it, `out_sample` is 0xFF, `out_slot` is 0 and `frame_start` is 0. The live table and the staging table are both straight-through: every output slot k reads input slot k and is not idle.
- R2: The input sample taken at a rising edge belongs to slot `n mod SLOTS`, where n counts edges from reset release starting at 0. After edge n, `out_sample` carries the sample that entered in input slot `src(k)` of the previous frame, where k = n mod SLOTS and `src(k)` is the live source index for output slot k.
- R3: `out_slot` after edge n equals n mod SLOTS, so it steps 0,1,…,SLOTS-1 and then wraps to 0. `frame_start` is 1 exactly when `out_slot` is 0.
- R4: If the live entry for an output slot has its idle flag set (`cfg_idle`=1 when it was written), that slot carries 0xFF and no memory sample.
- R5: A configuration write `{cfg_slot, cfg_src, cfg_idle}` taken at any edge, including the last slot's edge, goes live from the next output slot 0 onward. Output slots of the current frame keep the old entry.
- R6: During the first frame after reset (edges 0 to SLOTS-1) every output sample is 0xFF, because no complete frame is stored yet.
- R7: Several output slots may name the same input slot, and each of them carries a copy of that sample.
- R8: The write bank alternates at every frame boundary and is otherwise held. A stored sample is therefore read in the frame that follows its arrival and not later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sample | input | 8 | Multiplexed input sample for the current slot |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | $clog2(SLOTS) | Output slot whose entry is written |
| cfg_src | input | $clog2(SLOTS) | Input slot that feeds that output slot |
| cfg_idle | input | 1 | Marks the output slot idle (carries 0xFF) |
| out_sample | output | 8 | Interchanged output sample |
| out_slot | output | $clog2(SLOTS) | Slot index of `out_sample` |
| frame_start | output | 1 | High with output slot 0 |

## Verification
Every output is a single register stage past the edge that consumes the slot. Slot, frame flag and idle or priming results are therefore visible just after edge n. A permuted sample appears after edge n but comes from the input of edge `n - SLOTS + (src - k)`, one frame earlier. A table write becomes visible after the first edge whose slot is 0 and which follows the write. The bench drives and samples on falling edges. It keeps a frame-history model, and for each cycle it forms the value expected after the coming edge. It then compares at the next falling edge, so every result is read exactly one register stage after its cause.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int SAMPLE_W = 8;
  typedef logic [SAMPLE_W-1:0] sample_t;
  localparam sample_t IDLE_CODE = 8'hFF;
endpackage

// File: rtl/tsi_frame_seq.sv
module tsi_frame_seq #(
  parameter int SLOTS = 32,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] slot_cnt,
  output logic          frame_wrap,
  output logic          wr_bank
);
  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

  function automatic logic [AW-1:0] slot_after(input logic [AW-1:0] s);
    return (s == LAST) ? '0 : s + 1'b1;
  endfunction

  assign frame_wrap = (slot_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_cnt <= '0;
      wr_bank  <= 1'b0;
    end else begin
      slot_cnt <= slot_after(slot_cnt);
      if (frame_wrap) wr_bank <= ~wr_bank;
    end
  end
endmodule

// File: rtl/tsi_frame_mem.sv
module tsi_frame_mem #(
  parameter int SLOTS = 32,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             wr_bank,
  input  logic [AW-1:0]    wr_addr,
  input  tsi_pkg::sample_t wr_data,
  input  logic [AW-1:0]    rd_addr,
  output tsi_pkg::sample_t rd_data
);
  tsi_pkg::sample_t bank_out [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    tsi_pkg::sample_t mem [SLOTS];
    always_ff @(posedge clk) begin
      if (wr_bank == 1'(b)) mem[wr_addr] <= wr_data;
    end
    assign bank_out[b] = mem[rd_addr];
  end

  // the bank not being written holds the previous frame
  assign rd_data = bank_out[~wr_bank];
endmodule

// File: rtl/tsi_conn_map.sv
module tsi_conn_map #(
  parameter int SLOTS = 32,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [AW-1:0]           cfg_slot,
  input  logic [AW-1:0]           cfg_src,
  input  logic                    cfg_idle,
  input  logic                    commit,
  input  logic [AW-1:0]           rd_slot,
  output logic [AW-1:0]           rd_src,
  output logic                    rd_idle,
  output logic [SLOTS*(AW+1)-1:0] act_flat
);
  localparam int EW = AW + 1;

  function automatic logic [EW-1:0] home_entry(input int idx);
    return {1'b0, AW'(idx)};
  endfunction

  logic [EW-1:0] act_arr [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_ent
    logic [EW-1:0] sh_q, act_q, sh_next;
    logic          hit;
    assign hit     = cfg_we && (cfg_slot == AW'(i));
    assign sh_next = hit ? {cfg_idle, cfg_src} : sh_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_q  <= home_entry(i);
        act_q <= home_entry(i);
      end else begin
        sh_q <= sh_next;
        if (commit) act_q <= sh_next;
      end
    end
    assign act_arr[i]              = act_q;
    assign act_flat[i*EW +: EW]    = act_q;
  end

  logic [EW-1:0] rd_entry;
  assign rd_entry = act_arr[rd_slot];
  assign rd_src   = rd_entry[AW-1:0];
  assign rd_idle  = rd_entry[AW];
endmodule

// File: rtl/tsi_core.sv
module tsi_core #(
  parameter int SLOTS = 32,
  localparam int AW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    in_sample,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_slot,
  input  logic [AW-1:0] cfg_src,
  input  logic          cfg_idle,
  output logic [7:0]    out_sample,
  output logic [AW-1:0] out_slot,
  output logic          frame_start
);
  import tsi_pkg::*;

  logic [AW-1:0]           slot_cnt;
  logic                    frame_wrap;
  logic                    wr_bank;
  logic [AW-1:0]           rd_src;
  logic                    rd_idle;
  logic [SLOTS*(AW+1)-1:0] act_flat;
  sample_t                 rd_data;
  logic                    primed;

  tsi_frame_seq #(.SLOTS(SLOTS), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_cnt(slot_cnt),
    .frame_wrap(frame_wrap), .wr_bank(wr_bank)
  );

  tsi_conn_map #(.SLOTS(SLOTS), .AW(AW)) u_map (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_src(cfg_src), .cfg_idle(cfg_idle), .commit(frame_wrap),
    .rd_slot(slot_cnt), .rd_src(rd_src), .rd_idle(rd_idle),
    .act_flat(act_flat)
  );

  tsi_frame_mem #(.SLOTS(SLOTS), .AW(AW)) u_mem (
    .clk(clk), .wr_bank(wr_bank), .wr_addr(slot_cnt),
    .wr_data(in_sample), .rd_addr(rd_src), .rd_data(rd_data)
  );

  function automatic sample_t pick_out(input logic ready, input logic idle,
                                       input sample_t data);
    return (!ready || idle) ? IDLE_CODE : data;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed      <= 1'b0;
      out_sample  <= IDLE_CODE;
      out_slot    <= '0;
      frame_start <= 1'b0;
    end else begin
      if (frame_wrap) primed <= 1'b1;
      out_sample  <= pick_out(primed, rd_idle, rd_data);
      out_slot    <= slot_cnt;
      frame_start <= (slot_cnt == '0);
    end
  end
endmodule

// File: rtl/tsi_core_chk.sv
module tsi_core_chk #(
  parameter int SLOTS = 32,
  parameter int AW    = $clog2(SLOTS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [7:0]              out_sample,
  input logic [AW-1:0]           out_slot,
  input logic                    frame_start,
  input logic                    frame_wrap,
  input logic                    wr_bank,
  input logic                    rd_idle,
  input logic                    primed,
  input logic [SLOTS*(AW+1)-1:0] act_flat
);
  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);
  logic run;
  always_ff @(posedge clk) run <= rst_n;

  // R3
  frame_start_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> out_slot == '0);
  // R3
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && out_slot != LAST) |=> out_slot == $past(out_slot) + 1'b1);
  // R8
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> wr_bank != $past(wr_bank));
  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(wr_bank));
  // R5
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(act_flat));
  // R4
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idle |=> out_sample == 8'hFF);
  // R6
  prime_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> out_sample == 8'hFF);
endmodule

bind tsi_core tsi_core_chk #(.SLOTS(SLOTS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_sample(out_sample), .out_slot(out_slot),
  .frame_start(frame_start), .frame_wrap(frame_wrap), .wr_bank(wr_bank),
  .rd_idle(rd_idle), .primed(primed), .act_flat(act_flat)
);

// File: tb/test_tsi_core.sv
module test_tsi_core;
  localparam int S  = 32;
  localparam int AW = $clog2(S);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    in_sample = '0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_slot = '0, cfg_src = '0;
  logic          cfg_idle = 1'b0;
  logic [7:0]    out_sample;
  logic [AW-1:0] out_slot;
  logic          frame_start;

  always #4 clk = ~clk;   // 125 MHz

  tsi_core #(.SLOTS(S)) i_tsi_core (
    .clk(clk), .rst_n(rst_n), .in_sample(in_sample), .cfg_we(cfg_we),
    .cfg_slot(cfg_slot), .cfg_src(cfg_src), .cfg_idle(cfg_idle),
    .out_sample(out_sample), .out_slot(out_slot), .frame_start(frame_start)
  );

  int n_chk = 0, n_fail = 0, n_edge = 0;
  bit done = 0;

  // model of the requirements
  logic [7:0] m_hist [2][S];
  int  m_src [S], m_idle [S], sh_src [S], sh_idle [S];
  int  m_slot, m_bank;
  bit  m_primed;

  // scenario table: {mode[1:0], param[5:0]}
  // mode 0 straight, 1 reversed, 2 rotated by param, 3 param fans out to even slots, odd idle
  localparam logic [7:0] SCEN [5] = '{8'h40, 8'h85, 8'hC9, 8'h9F, 8'h00};

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 37 + 5) ^ (n >> 3));
  endfunction

  task automatic model_reset();
    for (int k = 0; k < S; k++) begin
      m_src[k] = k; m_idle[k] = 0; sh_src[k] = k; sh_idle[k] = 0;
    end
    m_slot = 0; m_bank = 0; m_primed = 0; n_edge = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; in_sample = '0;
    repeat (3) @(negedge clk);
    n_chk++;  // R1 reset state at ports
    if (out_sample !== 8'hFF || out_slot !== '0 || frame_start !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got %h/%0d/%b exp ff/0/0", out_sample, out_slot, frame_start);
    end
    model_reset();
    rst_n = 1'b1;
  endtask

  task automatic tick(input bit we, input int cs, input int src, input bit idl);
    logic [7:0] d, exp_s;
    string tag;
    int slot;
    d = pat(n_edge);
    in_sample = d; cfg_we = we; cfg_slot = AW'(cs); cfg_src = AW'(src); cfg_idle = idl;
    slot = m_slot;
    if (!m_primed)          begin exp_s = 8'hFF; tag = "R6"; end
    else if (m_idle[slot] != 0) begin exp_s = 8'hFF; tag = "R4"; end
    else begin exp_s = m_hist[1 - m_bank][m_src[slot]]; tag = "R2"; end  // R8 one-frame hold
    m_hist[m_bank][slot] = d;
    if (we) begin sh_src[cs] = src; sh_idle[cs] = idl; end
    if (slot == S - 1) begin  // R5 commit at frame boundary
      for (int k = 0; k < S; k++) begin m_src[k] = sh_src[k]; m_idle[k] = sh_idle[k]; end
      m_bank = 1 - m_bank; m_primed = 1;
    end
    m_slot = (slot + 1) % S;
    n_edge++;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    n_chk++;
    if (out_sample !== exp_s) begin
      n_fail++;
      $display("FAIL %s slot %0d: got %h exp %h", tag, slot, out_sample, exp_s);
    end
    n_chk++;  // R3 slot index and frame strobe
    if (out_slot !== AW'(slot) || frame_start !== (slot == 0)) begin
      n_fail++;
      $display("FAIL R3 slot: got %0d/%b exp %0d/%b", out_slot, frame_start, slot, slot == 0);
    end
  endtask

  task automatic idle_frame();
    for (int k = 0; k < S; k++) tick(0, 0, 0, 0);
  endtask

  initial begin
    do_reset();
    idle_frame();   // R6 first frame after reset is all idle
    idle_frame();   // R2 straight-through map from reset
    foreach (SCEN[e]) begin
      for (int k = 0; k < S; k++) begin  // program while previous map stays live (R5)
        int md, p, src, idl;
        md = int'(SCEN[e][7:6]); p = int'(SCEN[e][5:0]); idl = 0;
        case (md)
          0: src = k;
          1: src = S - 1 - k;
          2: src = (k + p) % S;
          default: begin src = p % S; idl = k % 2; end  // R7 fan-out, R4 idle slots
        endcase
        tick(1, k, src, idl[0]);
      end
      idle_frame();
    end
    // R5: mid-frame write does not disturb current frame, last-slot write goes live next frame
    for (int k = 0; k < S; k++) begin
      if (k == 4)          tick(1, 20, 3, 0);
      else if (k == S - 1) tick(1, 0, 7, 0);
      else                 tick(0, 0, 0, 0);
    end
    idle_frame();
    // R1/R6: reset in mid-frame restores straight map and priming
    for (int k = 0; k < 10; k++) tick(1, k, 5, 1);
    do_reset();
    idle_frame();
    idle_frame();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule